// File: doc/BRIEF.md
# Three-Phase PWM Output Override

This block sits between a three-phase complementary PWM generator and the output pins. It handles six outputs: for each of phases 0, 1 and 2 there is a true channel and an inverted channel. Each output either passes the live waveform from the generator or is held at a fixed high or low level chosen by software. A 16-bit control word is written over a simple register bus with two byte enables. The same word can be read back.

A buffer-mode input chooses when a write takes effect. In single-buffer mode the word applies from the next clock edge. In double-buffer mode the write lands in a shadow copy. The shadow then moves into the active copy on a selected PWM counter event: underflow, peak, either of the two, or none. Whenever the counter is stopped, the shadow moves across on every cycle and does not wait for an event.

The output selection is purely combinational from the active copy and the generator waveforms. A change in the active copy is therefore visible on the pins in the cycle right after the clock edge that loads it.

Top module: `pwm_ovr_top`

## Requirements
- R1: After reset the shadow and active copies are all zero, `rd_data` reads 0 and every output equals its `pwm_in` bit.
- R2: Output index i (0..5) is, in order, phase 0 true, phase 0 inverted, phase 1 true, phase 1 inverted, phase 2 true, phase 2 inverted. Level bit i is control bit i, and select bit i is control bit 6+i. `pwm_out[i]` equals level bit i when select bit i is 1, and equals `pwm_in[i]` when it is 0. This path is combinational.
- R3: Control bits 15:12 always read as 0, and writes to them have no effect.
- R4: `wr_be[0]` enables the write of bits 7:0 and `wr_be[1]` enables the write of bits 15:8. A write with both enables clear changes nothing.
- R5: With `buf_dbl`=0 a write reaches the active copy, and so the outputs, from the next clock edge. While `buf_dbl`=0 the active copy takes the shadow value plus any write on every edge.
- R6: With `buf_dbl`=1 a write updates only the shadow copy. While the counter runs and no selected event occurs, the active copy and the outputs stay unchanged.
- R7: `load_sel` chooses the load event when `buf_dbl`=1 and `cnt_run`=1: 00 selects an `ev_under` pulse, 01 selects an `ev_peak` pulse, 10 selects either pulse, and 11 selects no event. On a selected event the active copy takes the shadow copy.
- R8: With `buf_dbl`=1 and `cnt_run`=0, the active copy takes the shadow copy on every clock edge.
- R9: If a write and a load happen in the same cycle, the active copy takes the shadow value from before the write, and the new write stays in the shadow.
- R10: `rd_data` returns the shadow copy when `buf_dbl`=1 and the active copy when `buf_dbl`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write strobe for the control word |
| wr_be | input | 2 | Byte enables: bit 0 for bits 7:0, bit 1 for bits 15:8 |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data: the shadow or the active copy, with bits 15:12 zero |
| buf_dbl | input | 1 | 1 selects double-buffer mode, 0 selects single-buffer mode |
| load_sel | input | 2 | Load event select: 00 underflow, 01 peak, 10 either, 11 none |
| cnt_run | input | 1 | High while the PWM counter is running |
| ev_under | input | 1 | One-cycle pulse on counter underflow |
| ev_peak | input | 1 | One-cycle pulse on counter peak |
| pwm_in | input | 6 | Generator waveforms, ordered as in R2 |
| pwm_out | output | 6 | Waveforms driven to the pins |

## Verification
The hardest case to reach from the ports is a write that falls in the same cycle as a selected load event while the counter runs in double-buffer mode. The outputs must then show the old shadow value, and the new value must appear only at the following event. A case just as hard is a held shadow that is released only when the counter stops. Directed steps first place a known value in the shadow. They then pulse an event together with a different write, and check both the read-back and the pins across the next events. A long random phase follows. It mixes modes, select codes, run and stop periods and sparse event pulses, and compares the outputs against a behavioural model on every clock.

// File: rtl/pwm_ovr_pkg.sv
package pwm_ovr_pkg;

  typedef enum logic [1:0] {
    LD_UNDER  = 2'b00,
    LD_PEAK   = 2'b01,
    LD_EITHER = 2'b10,
    LD_NONE   = 2'b11
  } ld_sel_e;

  function automatic logic ev_hit(ld_sel_e sel, logic under, logic peak);
    logic hit;
    unique case (sel)
      LD_UNDER:  hit = under;
      LD_PEAK:   hit = peak;
      LD_EITHER: hit = under | peak;
      default:   hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/pwm_ovr_wrmask.sv
module pwm_ovr_wrmask #(
  parameter int unsigned CTRL_W = 12,
  parameter int unsigned BUS_W  = 16,
  localparam int unsigned LANES = BUS_W / 8
) (
  input  logic              wr_en,
  input  logic [LANES-1:0]  wr_be,
  input  logic [CTRL_W-1:0] wr_bits,
  input  logic [CTRL_W-1:0] cur_q,
  output logic [CTRL_W-1:0] nxt
);

  for (genvar b = 0; b < CTRL_W; b++) begin : g_bit
    localparam int unsigned LANE = b / 8;
    assign nxt[b] = (wr_en && wr_be[LANE]) ? wr_bits[b] : cur_q[b];
  end

endmodule

// File: rtl/pwm_ovr_loadsel.sv
module pwm_ovr_loadsel
  import pwm_ovr_pkg::*;
(
  input  logic    buf_dbl,
  input  logic    cnt_run,
  input  logic    ev_under,
  input  logic    ev_peak,
  input  ld_sel_e sel,
  output logic    load_now
);

  always_comb begin
    if (!buf_dbl) begin
      load_now = 1'b1;
    end else if (!cnt_run) begin
      load_now = 1'b1;
    end else begin
      load_now = ev_hit(sel, ev_under, ev_peak);
    end
  end

endmodule

// File: rtl/pwm_ovr_regs.sv
module pwm_ovr_regs #(
  parameter int unsigned CTRL_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              buf_dbl,
  input  logic              load_now,
  input  logic [CTRL_W-1:0] sh_nxt,
  output logic [CTRL_W-1:0] sh_q,
  output logic [CTRL_W-1:0] act_q
);

  logic [CTRL_W-1:0] act_d;
  logic              act_en;

  always_comb begin
    act_en = load_now;
    act_d  = buf_dbl ? sh_q : sh_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
    end else if (act_en) begin
      act_q <= act_d;
    end
  end

endmodule

// File: rtl/pwm_ovr_outmux.sv
module pwm_ovr_outmux #(
  parameter int unsigned NUM_OUT = 6,
  localparam int unsigned CTRL_W = 2 * NUM_OUT
) (
  input  logic [CTRL_W-1:0]  act_q,
  input  logic [NUM_OUT-1:0] pwm_in,
  output logic [NUM_OUT-1:0] pwm_out
);

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    logic force_lvl;
    assign force_lvl  = act_q[NUM_OUT + i];
    assign pwm_out[i] = force_lvl ? act_q[i] : pwm_in[i];
  end

endmodule

// File: rtl/pwm_ovr_top.sv
module pwm_ovr_top
  import pwm_ovr_pkg::*;
#(
  parameter int unsigned NUM_PHASE = 3,
  parameter int unsigned BUS_W     = 16,
  localparam int unsigned NUM_OUT  = 2 * NUM_PHASE,
  localparam int unsigned CTRL_W   = 2 * NUM_OUT,
  localparam int unsigned LANES    = BUS_W / 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [LANES-1:0]   wr_be,
  input  logic [BUS_W-1:0]   wr_data,
  output logic [BUS_W-1:0]   rd_data,
  input  logic               buf_dbl,
  input  logic [1:0]         load_sel,
  input  logic               cnt_run,
  input  logic               ev_under,
  input  logic               ev_peak,
  input  logic [NUM_OUT-1:0] pwm_in,
  output logic [NUM_OUT-1:0] pwm_out
);

  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic [CTRL_W-1:0] sh_q;
  logic [CTRL_W-1:0] act_q;
  logic [CTRL_W-1:0] sh_nxt;
  logic              load_now;
  logic [CTRL_W-1:0] rd_ctrl;
  logic              unused_hi;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  assign unused_hi = ^wr_data[BUS_W-1:CTRL_W];

  pwm_ovr_wrmask #(
    .CTRL_W (CTRL_W),
    .BUS_W  (BUS_W)
  ) u_wrmask (
    .wr_en   (wr_en),
    .wr_be   (wr_be),
    .wr_bits (wr_data[CTRL_W-1:0]),
    .cur_q   (sh_q),
    .nxt     (sh_nxt)
  );

  pwm_ovr_loadsel u_loadsel (
    .buf_dbl  (buf_dbl),
    .cnt_run  (cnt_run),
    .ev_under (ev_under),
    .ev_peak  (ev_peak),
    .sel      (ld_sel_e'(load_sel)),
    .load_now (load_now)
  );

  pwm_ovr_regs #(
    .CTRL_W (CTRL_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .buf_dbl  (buf_dbl),
    .load_now (load_now),
    .sh_nxt   (sh_nxt),
    .sh_q     (sh_q),
    .act_q    (act_q)
  );

  pwm_ovr_outmux #(
    .NUM_OUT (NUM_OUT)
  ) u_outmux (
    .act_q   (act_q),
    .pwm_in  (pwm_in),
    .pwm_out (pwm_out)
  );

  always_comb begin
    rd_ctrl = buf_dbl ? sh_q : act_q;
    rd_data = {{(BUS_W - CTRL_W){1'b0}}, rd_ctrl};
  end

endmodule

// File: rtl/pwm_ovr_chk.sv
module pwm_ovr_chk #(
  parameter int unsigned NUM_OUT = 6,
  parameter int unsigned BUS_W   = 16,
  localparam int unsigned CTRL_W = 2 * NUM_OUT,
  localparam int unsigned LANES  = BUS_W / 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [LANES-1:0]   wr_be,
  input logic [BUS_W-1:0]   wr_data,
  input logic [BUS_W-1:0]   rd_data,
  input logic               buf_dbl,
  input logic [1:0]         load_sel,
  input logic               cnt_run,
  input logic               ev_under,
  input logic               ev_peak,
  input logic [NUM_OUT-1:0] pwm_in,
  input logic [NUM_OUT-1:0] pwm_out,
  input logic [CTRL_W-1:0]  sh_q,
  input logic [CTRL_W-1:0]  act_q
);

  logic sel_ev;
  assign sel_ev = ((load_sel == 2'b00) && ev_under) ||
                  ((load_sel == 2'b01) && ev_peak)  ||
                  ((load_sel == 2'b10) && (ev_under || ev_peak));

  assert_pass_through_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q[CTRL_W-1:NUM_OUT] == '0) |-> (pwm_out == pwm_in));

  assert_force_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (&act_q[CTRL_W-1:NUM_OUT]) |-> (pwm_out == act_q[NUM_OUT-1:0]));

  assert_unused_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[BUS_W-1:CTRL_W] == '0);

  assert_single_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!buf_dbl && wr_en && wr_be[0]) |=> (act_q[7:0] == $past(wr_data[7:0])));

  assert_shadow_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_dbl && wr_en && wr_be[0]) |=> (sh_q[7:0] == $past(wr_data[7:0])));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_dbl && cnt_run && !sel_ev) |=> $stable(act_q));

  assert_event_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_dbl && cnt_run && sel_ev) |=> (act_q == $past(sh_q)));

  assert_stopped_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_dbl && !cnt_run) |=> (act_q == $past(sh_q)));

  assert_write_and_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_dbl && cnt_run && sel_ev && wr_en && (|wr_be)) |=> (act_q == $past(sh_q)));

  assert_read_shadow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    buf_dbl |-> (rd_data[CTRL_W-1:0] == sh_q));

  assert_read_active_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !buf_dbl |-> (rd_data[CTRL_W-1:0] == act_q));

endmodule

bind pwm_ovr_top pwm_ovr_chk #(
  .NUM_OUT (NUM_OUT),
  .BUS_W   (BUS_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .wr_en    (wr_en),
  .wr_be    (wr_be),
  .wr_data  (wr_data),
  .rd_data  (rd_data),
  .buf_dbl  (buf_dbl),
  .load_sel (load_sel),
  .cnt_run  (cnt_run),
  .ev_under (ev_under),
  .ev_peak  (ev_peak),
  .pwm_in   (pwm_in),
  .pwm_out  (pwm_out),
  .sh_q     (sh_q),
  .act_q    (act_q)
);

// File: tb/pwm_ovr_top_tb_top.sv
`timescale 1ns/1ps
module pwm_ovr_top_tb_top;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_be;
  logic [15:0] wr_data;
  logic [15:0] rd_data;
  logic        buf_dbl;
  logic [1:0]  load_sel;
  logic        cnt_run;
  logic        ev_under;
  logic        ev_peak;
  logic [5:0]  pwm_in;
  logic [5:0]  pwm_out;

  int    n_cmp;
  int    n_bad;
  bit    done;
  string cur_req;

  logic [11:0] m_sh;
  logic [11:0] m_act;

  pwm_ovr_top dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_be    (wr_be),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .buf_dbl  (buf_dbl),
    .load_sel (load_sel),
    .cnt_run  (cnt_run),
    .ev_under (ev_under),
    .ev_peak  (ev_peak),
    .pwm_in   (pwm_in),
    .pwm_out  (pwm_out)
  );

  // 50 MHz
  initial clk = 1'b0;
  always #10 clk = ~clk;

  // behavioural reference model, updated on each rising edge
  always @(posedge clk or negedge rst_n) begin
    logic [11:0] nsh;
    bit          ev;
    if (!rst_n) begin
      m_sh  <= 12'h000;
      m_act <= 12'h000;
    end else begin
      nsh = m_sh;
      if (wr_en && wr_be[0]) nsh[7:0]  = wr_data[7:0];
      if (wr_en && wr_be[1]) nsh[11:8] = wr_data[11:8];
      case (load_sel)
        2'b00:   ev = ev_under;
        2'b01:   ev = ev_peak;
        2'b10:   ev = ev_under || ev_peak;
        default: ev = 0;
      endcase
      m_sh <= nsh;
      if (!buf_dbl)             m_act <= nsh;
      else if (!cnt_run || ev)  m_act <= m_sh;
    end
  end

  // compare on every clock, away from the edge
  always @(posedge clk) begin
    logic [15:0] e_rd;
    logic [5:0]  e_out;
    #5;
    if (!done) begin
      e_rd = {4'h0, (buf_dbl ? m_sh : m_act)};
      for (int i = 0; i < 6; i++)
        e_out[i] = m_act[6+i] ? m_act[i] : pwm_in[i];
      n_cmp++;
      if (rd_data !== e_rd) begin
        n_bad++;
        $display("FAIL %s rd_data actual=%h expected=%h t=%0t", cur_req, rd_data, e_rd, $time);
      end
      n_cmp++;
      if (pwm_out !== e_out) begin
        n_bad++;
        $display("FAIL %s pwm_out actual=%b expected=%b t=%0t", cur_req, pwm_out, e_out, $time);
      end
    end
  end

  task automatic step(input logic w, input logic [1:0] be, input logic [15:0] d,
                      input logic u, input logic p);
    @(negedge clk);
    wr_en    = w;
    wr_be    = be;
    wr_data  = d;
    ev_under = u;
    ev_peak  = p;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      step(0, 2'b00, 16'h0000, 0, 0);
      pwm_in = 6'($urandom);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    n_cmp = 0; n_bad = 0; done = 0;
    cur_req = "R1";
    rst_n = 0; wr_en = 0; wr_be = 0; wr_data = 0;
    buf_dbl = 0; load_sel = 0; cnt_run = 1; ev_under = 0; ev_peak = 0;
    pwm_in = 6'b101010;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state, outputs follow the generator for several patterns
    idle(6);

    // R5 / R2: single-buffer writes act on the next edge
    cur_req = "R5";
    step(1, 2'b11, 16'h0FC5, 0, 0);
    cur_req = "R2";
    idle(4);
    step(1, 2'b11, 16'h0A3C, 0, 0);
    idle(4);
    step(1, 2'b11, 16'h0FC0, 0, 0); // all forced low
    idle(3);

    // R3: upper nibble ignored, reads zero
    cur_req = "R3";
    step(1, 2'b11, 16'hF000, 0, 0);
    idle(2);
    step(1, 2'b11, 16'hFFFF, 0, 0);
    idle(2);

    // R4: byte lanes
    cur_req = "R4";
    step(1, 2'b01, 16'hAA55, 0, 0);
    idle(2);
    step(1, 2'b10, 16'h0300, 0, 0);
    idle(2);
    step(1, 2'b00, 16'hFFFF, 0, 0);
    idle(2);

    // R6: double-buffer, running, no event
    cur_req = "R6";
    buf_dbl = 1; cnt_run = 1; load_sel = 2'b00;
    step(1, 2'b11, 16'h0ABC, 0, 0);
    idle(4);

    // R7: event selection
    cur_req = "R7";
    step(0, 2'b00, 16'h0000, 0, 1); // peak ignored under code 00
    idle(2);
    step(0, 2'b00, 16'h0000, 1, 0); // underflow loads
    idle(2);
    load_sel = 2'b01;
    step(1, 2'b11, 16'h0F0F, 0, 0);
    step(0, 2'b00, 16'h0000, 1, 0); // underflow ignored
    idle(2);
    step(0, 2'b00, 16'h0000, 0, 1); // peak loads
    idle(2);
    load_sel = 2'b10;
    step(1, 2'b11, 16'h00F0, 0, 0);
    step(0, 2'b00, 16'h0000, 1, 0);
    step(1, 2'b11, 16'h0FFF, 0, 0);
    step(0, 2'b00, 16'h0000, 0, 1);
    idle(2);
    load_sel = 2'b11;
    step(1, 2'b11, 16'h0555, 0, 0);
    step(0, 2'b00, 16'h0000, 1, 1); // no event selected
    idle(2);

    // R9: write in the same cycle as a load
    cur_req = "R9";
    load_sel = 2'b00;
    step(1, 2'b11, 16'h0123, 1, 0);
    idle(3);
    step(1, 2'b11, 16'h0FC3, 1, 0);
    idle(2);
    step(0, 2'b00, 16'h0000, 1, 0);
    idle(2);

    // R8: counter stopped loads every cycle
    cur_req = "R8";
    load_sel = 2'b11;
    step(1, 2'b11, 16'h0E1D, 0, 0);
    idle(2);
    cnt_run = 0;
    idle(2);
    step(1, 2'b01, 16'h0077, 0, 0);
    idle(3);
    cnt_run = 1;

    // R10: read source follows the mode
    cur_req = "R10";
    step(1, 2'b11, 16'h0333, 0, 0);
    idle(2);
    buf_dbl = 0;
    idle(3);
    buf_dbl = 1;
    step(1, 2'b11, 16'h0CCC, 0, 0);
    idle(2);

    // mixed random traffic
    cur_req = "R7";
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r;
      r = $urandom;
      @(negedge clk);
      wr_en    = (r[3:0] < 4);
      wr_be    = r[5:4];
      wr_data  = r[31:16];
      ev_under = (r[9:6] == 0);
      ev_peak  = (r[13:10] == 1);
      pwm_in   = 6'($urandom);
      if (r[15:14] == 0 && $urandom_range(0, 15) == 0) buf_dbl = ~buf_dbl;
      if ($urandom_range(0, 31) == 0) cnt_run = ~cnt_run;
      if ($urandom_range(0, 63) == 0) load_sel = 2'($urandom);
    end
    idle(3);
    finish_run();
  end

endmodule